// File: doc/BRIEF.md
# Trusted-Module FIFO Register Block

This block is the device-side register file of a trusted-module FIFO interface. A host reaches it through a simple synchronous memory-mapped bus. The bus has an address, a write strobe, a read strobe and a width flag that selects a byte or a 32-bit word, plus write data and read data. Behind the registers sits a byte buffer. The host fills this buffer with a command through a single data port, and later drains the response from it through the same port. A separate command engine, which is outside this block, gets a start pulse. It can read the command bytes, write the response bytes and then signal completion. The block drives one level-sensitive interrupt line.

The host must first claim the single supported locality (locality 0). Until it has the locality, the block ignores every register write other than the locality request, and reads of the data port and the status register return all ones. Interrupt status bits are cleared by writing ones to them, but only while the locality is held. The status register reports four things: whether the block is ready for a command, whether it still expects command bytes, whether response bytes are waiting, and how many bytes can be moved without waiting. The data-expected flag follows the big-endian length field carried in command bytes 2 to 5.

Top module: `tmod_fifo_regs`

## Requirements
- R1: After reset no locality is held, the access register (0x00) reads 0x80, the interrupt status (0x10) and interrupt enable (0x08) read 0, the status register (0x18) reads 0xFFFFFFFF, and irq_o is low.
- R2: Writing a byte with bit 1 set to 0x00 while the locality is free grants it. Writing bit 5 while the locality is held releases it. The access register reads bit 7 = 1 (valid) and bit 5 = locality held. Each grant or release sets interrupt status bit 2.
- R3: While no locality is held, writes to 0x08, 0x0C, 0x10, 0x18 and 0x24 have no effect, and reads of 0x18 and 0x24 return 0xFFFFFFFF.
- R4: Interrupt status bits 7, 2, 1 and 0 are cleared by writing 1 to them at 0x10, but only while the locality is held. If an event sets a bit in the same cycle as a clear, the bit stays set.
- R5: irq_o is high exactly when enable bit 31 (global) is set and some status bit among 7, 2, 1 and 0 is set along with the same bit in the enable register. Enable bit 31 changes only on word-wide writes. irq_vec shows the byte last written to 0x0C.
- R6: 0x14 reads 0x30000000 (interface version 3 in bits 30:28). 0x30, 0xF00 and 0xF04 read the parameter constants for interface id, device/vendor id and revision. Unmapped addresses read 0.
- R7: A status write with bit 6 set, when no command is executing, empties the buffer and enters the ready phase. Status bit 6 then reads 1, data-expected (bit 3) reads 1, and interrupt status bit 7 is set if the phase was not already ready.
- R8: In the ready or receiving phase, each byte written to 0x24 is appended to the buffer while space remains; bytes beyond the buffer size are dropped. Data-expected stays 1 until at least 6 bytes are held and the byte count is at least the big-endian length in bytes 2 to 5. Each byte that leaves the command complete sets interrupt status bit 1.
- R9: A status write with bit 5 set and bit 6 clear starts the command only if the command is complete. The engine then sees a one-cycle eng_start pulse in the cycle after the write, and eng_rd_data shows buffer byte eng_rd_idx. In any other case the write is ignored.
- R10: A status write with bit 6 set during execution gives a one-cycle eng_cancel pulse in the next cycle. The block stays in execution (status bit 6 reads 0) until eng_done.
- R11: During execution, eng_wr writes buffer bytes. On eng_done the response length becomes eng_rsp_len, capped at the buffer size. Data-available (bit 4) then reads 1 while unread bytes remain, and interrupt status bit 0 is set if the length is non-zero. Reads of 0x24 return the response bytes in order, and 0xFF once all have been read.
- R12: Burst count (status bits 23:8) equals the free buffer space in the ready or receiving phase, the number of unread response bytes after completion, and 0 otherwise. Status bit 7 reads 1 while the locality is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the response pointer on 0x24) |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access on bits 7:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_o | output | 1 | Level interrupt |
| irq_vec | output | 8 | Interrupt vector register |
| eng_start | output | 1 | One-cycle command start pulse |
| eng_cancel | output | 1 | One-cycle command cancel pulse |
| eng_done | input | 1 | Engine response ready |
| eng_rsp_len | input | CNT_W | Response length in bytes |
| eng_wr | input | 1 | Engine buffer write |
| eng_wr_idx | input | IDX_W | Engine write index |
| eng_wr_data | input | 8 | Engine write byte |
| eng_rd_idx | input | IDX_W | Engine read index |
| eng_rd_data | output | 8 | Buffer byte at eng_rd_idx |

## Verification
The hardest behaviours to reach are those that depend on the order of locality and command events. Examples are a clear attempt on a pending interrupt right after the locality has been released, a cancel issued while the engine is still busy, and a command whose length field is larger than the buffer. The stimulus gets there with scripted sequences. Each sequence first builds the needed state (locality held, pending bits, a partly written command) and then releases the locality or overflows the buffer before it probes the registers. A behavioural model tracks the phase, byte counts and flags, and it is checked against the interrupt and engine outputs on every clock and against every bus read.

// File: rtl/tmod_pkg.sv
`timescale 1ns/1ps
package tmod_pkg;
    localparam logic [11:0] A_ACC  = 12'h000;
    localparam logic [11:0] A_IEN  = 12'h008;
    localparam logic [11:0] A_IVEC = 12'h00C;
    localparam logic [11:0] A_ISTS = 12'h010;
    localparam logic [11:0] A_CAPS = 12'h014;
    localparam logic [11:0] A_STS  = 12'h018;
    localparam logic [11:0] A_DATA = 12'h024;
    localparam logic [11:0] A_IFID = 12'h030;
    localparam logic [11:0] A_DVID = 12'hF00;
    localparam logic [11:0] A_REV  = 12'hF04;

    localparam logic [31:0] IEN_MASK  = 32'h8000_0087;
    localparam logic [31:0] CAPS_WORD = 32'h3000_0000;

    typedef enum logic [2:0] {
        PH_IDLE, PH_READY, PH_RECV, PH_EXEC, PH_DONE
    } phase_e;

    // packed order matches compressed status vector [3]=b7 [2]=b2 [1]=b1 [0]=b0
    typedef struct packed {
        logic cmd_rdy;
        logic loc_chg;
        logic sts_vld;
        logic dat_avl;
    } irq_evt_t;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        word;
        logic [11:0] addr;
        logic [31:0] wdata;
    } bus_req_t;

    function automatic logic [3:0] pack_isr(input logic [31:0] w);
        return {w[7], w[2], w[1], w[0]};
    endfunction

    function automatic logic [31:0] unpack_isr(input logic [3:0] s);
        return {24'h0, s[3], 4'b0000, s[2], s[1], s[0]};
    endfunction
endpackage

// File: rtl/tmod_locality.sv
`timescale 1ns/1ps
module tmod_locality (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_wr,
    input  logic [7:0] acc_byte,
    output logic       loc_active,
    output logic       loc_evt
);
    logic grant, release_req;

    always_comb begin
        grant       = acc_wr && !loc_active && acc_byte[1];
        release_req = acc_wr &&  loc_active && acc_byte[5];
        loc_evt     = grant || release_req;
    end

    always_ff @(posedge clk) begin
        if (rst)              loc_active <= 1'b0;
        else if (grant)       loc_active <= 1'b1;
        else if (release_req) loc_active <= 1'b0;
    end
endmodule

// File: rtl/tmod_cmd_path.sv
`timescale 1ns/1ps
module tmod_cmd_path
    import tmod_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    localparam int CNT_W = $clog2(BUF_BYTES + 1),
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loc_active,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [7:0]       dat_wbyte,
    input  logic             sts_wr,
    input  logic [7:0]       sts_byte,
    output logic [7:0]       rd_byte,
    output phase_e           phase,
    output logic [15:0]      burst,
    output logic             data_exp,
    output logic             data_avl,
    output logic             evt_ready,
    output logic             evt_valid,
    output logic             evt_avail,
    output logic             eng_start,
    output logic             eng_cancel,
    input  logic             eng_done,
    input  logic [CNT_W-1:0] eng_rsp_len,
    input  logic             eng_wr,
    input  logic [IDX_W-1:0] eng_wr_idx,
    input  logic [7:0]       eng_wr_data,
    input  logic [IDX_W-1:0] eng_rd_idx,
    output logic [7:0]       eng_rd_data
);
    localparam int HDR_MIN = 6;

    logic [7:0]       mem [BUF_BYTES];
    logic [CNT_W-1:0] cnt, rd_ptr, rsp_len, rsp_n;
    logic [31:0]      len_cur, len_eff, cnt_next32;
    logic             complete, wr_ok, rd_ok, rdy_req, go_ok, cancel, to_ready, done_in;

    always_comb begin
        len_cur    = {mem[2], mem[3], mem[4], mem[5]};
        len_eff    = (cnt == CNT_W'(5)) ? {mem[2], mem[3], mem[4], dat_wbyte} : len_cur;
        cnt_next32 = 32'(cnt) + 32'd1;
        complete   = (phase == PH_RECV) && (cnt >= CNT_W'(HDR_MIN)) && (32'(cnt) >= len_cur);
        wr_ok      = loc_active && dat_wr && (phase == PH_READY || phase == PH_RECV)
                     && (cnt < CNT_W'(BUF_BYTES));
        evt_valid  = wr_ok && (cnt_next32 >= 32'(HDR_MIN)) && (cnt_next32 >= len_eff);
        rdy_req    = loc_active && sts_wr && sts_byte[6];
        cancel     = rdy_req && (phase == PH_EXEC);
        to_ready   = rdy_req && (phase != PH_EXEC);
        evt_ready  = to_ready && (phase != PH_READY);
        go_ok      = loc_active && sts_wr && sts_byte[5] && !sts_byte[6] && complete;
        done_in    = (phase == PH_EXEC) && eng_done;
        rsp_n      = (eng_rsp_len > CNT_W'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : eng_rsp_len;
        evt_avail  = done_in && (rsp_n != '0);
        data_avl   = (phase == PH_DONE) && (rd_ptr < rsp_len);
        rd_ok      = loc_active && dat_rd && data_avl;
        data_exp   = (phase == PH_READY) || ((phase == PH_RECV) && !complete);
        rd_byte    = data_avl ? mem[rd_ptr[IDX_W-1:0]] : 8'hFF;
        eng_rd_data = mem[eng_rd_idx];
        unique case (phase)
            PH_READY, PH_RECV: burst = 16'(BUF_BYTES) - 16'(cnt);
            PH_DONE:           burst = 16'(rsp_len) - 16'(rd_ptr);
            default:           burst = 16'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            rd_ptr     <= '0;
            rsp_len    <= '0;
            eng_start  <= 1'b0;
            eng_cancel <= 1'b0;
        end else begin
            eng_start  <= go_ok;
            eng_cancel <= cancel;
            if (to_ready) begin
                phase <= PH_READY;
                cnt   <= '0;
            end else if (go_ok) begin
                phase <= PH_EXEC;
            end else if (wr_ok) begin
                phase <= PH_RECV;
                cnt   <= cnt + 1'b1;
            end else if (done_in) begin
                phase   <= PH_DONE;
                rsp_len <= rsp_n;
                rd_ptr  <= '0;
            end else if (rd_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[cnt[IDX_W-1:0]] <= dat_wbyte;
        else if (eng_wr && phase == PH_EXEC)
            mem[eng_wr_idx] <= eng_wr_data;
    end
endmodule

// File: rtl/tmod_irq_unit.sv
`timescale 1ns/1ps
module tmod_irq_unit
    import tmod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        loc_active,
    input  logic        ien_wr,
    input  logic        ivec_wr,
    input  logic        ists_wr,
    input  logic        word,
    input  logic [31:0] wdata,
    input  irq_evt_t    evt,
    output logic [31:0] ien,
    output logic [7:0]  ivec,
    output logic [3:0]  ists,
    output logic        irq
);
    logic [3:0] clr, ien_c;

    always_comb begin
        clr   = (ists_wr && loc_active) ? pack_isr(wdata) : 4'b0;
        ien_c = pack_isr(ien);
        irq   = ien[31] && |(ists & ien_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= '0;
            ivec <= '0;
            ists <= '0;
        end else begin
            ists <= (ists & ~clr) | evt;
            if (ien_wr && loc_active)
                ien <= (word ? wdata : {ien[31:8], wdata[7:0]}) & IEN_MASK;
            if (ivec_wr && loc_active)
                ivec <= wdata[7:0];
        end
    end
endmodule

// File: rtl/tmod_fifo_regs.sv
`timescale 1ns/1ps
module tmod_fifo_regs
    import tmod_pkg::*;
#(
    parameter int          BUF_BYTES  = 16,
    parameter logic [31:0] IFACE_ID   = 32'h0000_0F00,
    parameter logic [31:0] DEV_VEN_ID = 32'h0001_5A3C,
    parameter logic [7:0]  REV_ID     = 8'h02,
    localparam int CNT_W = $clog2(BUF_BYTES + 1),
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [11:0]      bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_word,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o,
    output logic [7:0]       irq_vec,
    output logic             eng_start,
    output logic             eng_cancel,
    input  logic             eng_done,
    input  logic [CNT_W-1:0] eng_rsp_len,
    input  logic             eng_wr,
    input  logic [IDX_W-1:0] eng_wr_idx,
    input  logic [7:0]       eng_wr_data,
    input  logic [IDX_W-1:0] eng_rd_idx,
    output logic [7:0]       eng_rd_data
);
    bus_req_t    req;
    irq_evt_t    evt;
    phase_e      phase;
    logic        loc_active, loc_evt;
    logic [31:0] ien;
    logic [3:0]  ists;
    logic [15:0] burst;
    logic [7:0]  rd_byte;
    logic        data_exp, data_avl, evt_ready, evt_valid, evt_avail;
    logic [31:0] sts_word;

    assign req = '{wr: bus_wr, rd: bus_rd, word: bus_word, addr: bus_addr, wdata: bus_wdata};

    tmod_locality u_loc (
        .clk(clk), .rst(rst),
        .acc_wr(req.wr && req.addr == A_ACC), .acc_byte(req.wdata[7:0]),
        .loc_active(loc_active), .loc_evt(loc_evt)
    );

    tmod_cmd_path #(.BUF_BYTES(BUF_BYTES)) u_cmd (
        .clk(clk), .rst(rst), .loc_active(loc_active),
        .dat_wr(req.wr && req.addr == A_DATA), .dat_rd(req.rd && req.addr == A_DATA),
        .dat_wbyte(req.wdata[7:0]),
        .sts_wr(req.wr && req.addr == A_STS), .sts_byte(req.wdata[7:0]),
        .rd_byte(rd_byte), .phase(phase), .burst(burst),
        .data_exp(data_exp), .data_avl(data_avl),
        .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_avail(evt_avail),
        .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_done(eng_done),
        .eng_rsp_len(eng_rsp_len), .eng_wr(eng_wr), .eng_wr_idx(eng_wr_idx),
        .eng_wr_data(eng_wr_data), .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data)
    );

    assign evt = '{cmd_rdy: evt_ready, loc_chg: loc_evt, sts_vld: evt_valid, dat_avl: evt_avail};

    tmod_irq_unit u_irq (
        .clk(clk), .rst(rst), .loc_active(loc_active),
        .ien_wr(req.wr && req.addr == A_IEN), .ivec_wr(req.wr && req.addr == A_IVEC),
        .ists_wr(req.wr && req.addr == A_ISTS), .word(req.word), .wdata(req.wdata),
        .evt(evt), .ien(ien), .ivec(irq_vec), .ists(ists), .irq(irq_o)
    );

    assign sts_word = {8'h00, burst, 1'b1, (phase == PH_READY), 1'b0, data_avl, data_exp, 3'b000};

    always_comb begin
        unique case (req.addr)
            A_ACC:   bus_rdata = {24'h0, 1'b1, 1'b0, loc_active, 5'b0};
            A_IEN:   bus_rdata = ien;
            A_IVEC:  bus_rdata = {24'h0, irq_vec};
            A_ISTS:  bus_rdata = unpack_isr(ists);
            A_CAPS:  bus_rdata = CAPS_WORD;
            A_STS:   bus_rdata = loc_active ? sts_word : 32'hFFFF_FFFF;
            A_DATA:  bus_rdata = loc_active ? {24'h0, rd_byte} : 32'hFFFF_FFFF;
            A_IFID:  bus_rdata = IFACE_ID;
            A_DVID:  bus_rdata = DEV_VEN_ID;
            A_REV:   bus_rdata = {24'h0, REV_ID};
            default: bus_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/tmod_fifo_regs_chk.sv
`timescale 1ns/1ps
module tmod_fifo_regs_chk
    import tmod_pkg::*;
#(
    parameter int BUF_BYTES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        loc_active,
    input logic [3:0]  ists,
    input logic [31:0] ien,
    input logic        irq_o,
    input logic        eng_start,
    input logic        eng_cancel,
    input phase_e      phase,
    input logic [15:0] burst,
    input logic        bus_wr,
    input logic [11:0] bus_addr
);
    // R2: every grant or release leaves the locality-change flag set
    a_r2_loc_change_flag: assert property (@(posedge clk) disable iff (rst)
        (loc_active != $past(loc_active)) |-> ists[2]);

    // R3: data write without locality leaves the buffer state alone
    a_r3_data_ignored: assert property (@(posedge clk) disable iff (rst)
        (!loc_active && bus_wr && bus_addr == A_DATA && phase != PH_EXEC) |=> $stable(burst));

    // R4: no status bit drops when the clear is issued without locality
    a_r4_no_clear_unheld: assert property (@(posedge clk) disable iff (rst)
        (!loc_active && bus_wr && bus_addr == A_ISTS) |=> (($past(ists) & ~ists) == 4'b0));

    // R5: interrupt line needs the global enable
    a_r5_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ien[31]);

    // R9: start is a single-cycle pulse
    a_r9_start_single: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R10: cancel only follows an executing phase
    a_r10_cancel_in_exec: assert property (@(posedge clk) disable iff (rst)
        eng_cancel |-> $past(phase) == PH_EXEC);

    // R12: burst count never exceeds the buffer
    a_r12_burst_bound: assert property (@(posedge clk) disable iff (rst)
        burst <= 16'(BUF_BYTES));
endmodule

bind tmod_fifo_regs tmod_fifo_regs_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk(clk), .rst(rst), .loc_active(loc_active), .ists(ists), .ien(ien),
    .irq_o(irq_o), .eng_start(eng_start), .eng_cancel(eng_cancel), .phase(phase),
    .burst(burst), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/tmod_fifo_regs_tb_top.sv
`timescale 1ns/1ps
module tmod_fifo_regs_tb_top;
    localparam int BB = 16;
    localparam int CW = $clog2(BB + 1);
    localparam int IW = $clog2(BB);
    localparam logic [31:0] IFID = 32'h0000_0F00;
    localparam logic [31:0] DVID = 32'h0001_5A3C;
    localparam logic [7:0]  REVV = 8'h02;

    logic clk = 1'b0, rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0, bus_word = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq_o, eng_start, eng_cancel;
    logic [7:0] irq_vec, eng_rd_data;
    logic eng_done = 0, eng_wr = 0;
    logic [CW-1:0] eng_rsp_len = '0;
    logic [IW-1:0] eng_wr_idx = '0, eng_rd_idx = '0;
    logic [7:0] eng_wr_data = '0;

    tmod_fifo_regs #(.BUF_BYTES(BB), .IFACE_ID(IFID), .DEV_VEN_ID(DVID), .REV_ID(REVV)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .irq_vec(irq_vec), .eng_start(eng_start), .eng_cancel(eng_cancel),
        .eng_done(eng_done), .eng_rsp_len(eng_rsp_len), .eng_wr(eng_wr),
        .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data), .eng_rd_idx(eng_rd_idx),
        .eng_rd_data(eng_rd_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit run = 0, finished = 0;
    logic [31:0] last_rd;

    // behavioural reference model
    bit m_loc = 0;
    int m_ph = 0; // 0 idle 1 ready 2 recv 3 exec 4 done
    int m_cnt = 0, m_rsp = 0, m_rd = 0;
    logic [7:0] m_buf [BB];
    logic [31:0] m_en = 0, m_sts = 0;
    logic [7:0] m_vec = 0;
    bit m_start = 0, m_cancel = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit m_complete();
        logic [31:0] len = {m_buf[2], m_buf[3], m_buf[4], m_buf[5]};
        return (m_ph == 2) && (m_cnt >= 6) && (32'(m_cnt) >= len);
    endfunction

    function automatic bit m_irq();
        return m_en[31] && ((m_en & m_sts & 32'h87) != 0);
    endfunction

    function automatic logic [31:0] m_status();
        int b = 0;
        bit avl = (m_ph == 4) && (m_rd < m_rsp);
        bit dexp = (m_ph == 1) || (m_ph == 2 && !m_complete());
        if (m_ph == 1 || m_ph == 2) b = BB - m_cnt;
        else if (m_ph == 4) b = m_rsp - m_rd;
        return {8'h0, 16'(b), 1'b1, (m_ph == 1), 1'b0, avl, dexp, 3'b0};
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return 32'h80 | (m_loc ? 32'h20 : 32'h0);
            12'h008: return m_en;
            12'h00C: return {24'h0, m_vec};
            12'h010: return m_sts;
            12'h014: return 32'h3000_0000;
            12'h018: return m_loc ? m_status() : 32'hFFFF_FFFF;
            12'h024: return !m_loc ? 32'hFFFF_FFFF :
                            ((m_ph == 4 && m_rd < m_rsp) ? {24'h0, m_buf[m_rd]} : 32'hFF);
            12'h030: return IFID;
            12'hF00: return DVID;
            12'hF04: return {24'h0, REVV};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_write(input logic [11:0] a, input logic [31:0] d, input bit w);
        if (a == 12'h000) begin
            if (!m_loc && d[1]) begin m_loc = 1; m_sts |= 32'h4; end
            else if (m_loc && d[5]) begin m_loc = 0; m_sts |= 32'h4; end
            return;
        end
        if (!m_loc) return;
        case (a)
            12'h008: m_en = (w ? d : {m_en[31:8], d[7:0]}) & 32'h8000_0087;
            12'h00C: m_vec = d[7:0];
            12'h010: m_sts &= ~(d & 32'h87);
            12'h018: begin
                if (d[6]) begin
                    if (m_ph == 3) m_cancel = 1;
                    else begin
                        if (m_ph != 1) m_sts |= 32'h80;
                        m_ph = 1; m_cnt = 0;
                    end
                end else if (d[5] && m_complete()) begin
                    m_ph = 3; m_start = 1;
                end
            end
            12'h024: if ((m_ph == 1 || m_ph == 2) && m_cnt < BB) begin
                m_buf[m_cnt] = d[7:0]; m_cnt++; m_ph = 2;
                if (m_complete()) m_sts |= 32'h2;
            end
            default: ;
        endcase
    endtask

    // per-clock comparison of the outputs with the model
    always @(negedge clk) if (run && !finished) begin
        chk("R5 irq_o", {31'h0, irq_o}, {31'h0, m_irq()});
        chk("R5 irq_vec", {24'h0, irq_vec}, {24'h0, m_vec});
        chk("R9 eng_start", {31'h0, eng_start}, {31'h0, m_start});
        chk("R10 eng_cancel", {31'h0, eng_cancel}, {31'h0, m_cancel});
    end

    task automatic finish_op();
        @(posedge clk); #1;
        m_start = 0; m_cancel = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit w = 0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1;
        @(posedge clk);
        m_write(a, d, w);
        #1 bus_wr = 0;
        finish_op();
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1;
        last_rd = bus_rdata;
        chk(req, bus_rdata, m_read(a));
        @(posedge clk);
        if (a == 12'h024 && m_loc && m_ph == 4 && m_rd < m_rsp) m_rd++;
        #1 bus_rd = 0;
        finish_op();
    endtask

    task automatic eng_write(input int idx, input logic [7:0] d);
        @(negedge clk);
        eng_wr = 1; eng_wr_idx = IW'(idx); eng_wr_data = d;
        @(posedge clk);
        if (m_ph == 3) m_buf[idx] = d;
        #1 eng_wr = 0;
        finish_op();
    endtask

    task automatic eng_finish(input int len);
        @(negedge clk);
        eng_done = 1; eng_rsp_len = CW'(len);
        @(posedge clk);
        if (m_ph == 3) begin
            m_rsp = (len > BB) ? BB : len; m_rd = 0; m_ph = 4;
            if (m_rsp > 0) m_sts |= 32'h1;
        end
        #1 eng_done = 0;
        finish_op();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        run = 1;
        // R1 reset state
        rd("R1 access", 12'h000);   chk("R1 access lit", last_rd, 32'h80);
        rd("R1 status", 12'h018);   chk("R1 status lit", last_rd, 32'hFFFF_FFFF);
        rd("R1 int sts", 12'h010);
        rd("R1 int en", 12'h008);
        // R3 writes without locality are dropped
        wr(12'h008, 32'h8000_0087, 1);
        wr(12'h00C, 32'h5, 0);
        wr(12'h018, 32'h40);
        wr(12'h024, 32'hAA);
        rd("R3 int en", 12'h008);   chk("R3 int en lit", last_rd, 32'h0);
        rd("R3 data", 12'h024);     chk("R3 data lit", last_rd, 32'hFFFF_FFFF);
        // R6 constants
        rd("R6 caps", 12'h014);     chk("R6 caps lit", last_rd, 32'h3000_0000);
        rd("R6 ifid", 12'h030);
        rd("R6 dvid", 12'hF00);
        rd("R6 rev", 12'hF04);
        rd("R6 unmapped", 12'h040);
        // R2 grant
        wr(12'h000, 32'h02);
        rd("R2 access held", 12'h000); chk("R2 access lit", last_rd, 32'hA0);
        rd("R2 loc flag", 12'h010);    chk("R2 loc flag lit", last_rd, 32'h4);
        // R5 enable; byte write cannot set bit 31
        wr(12'h008, 32'hFFFF_FF87, 0);
        rd("R5 en byte", 12'h008);     chk("R5 en byte lit", last_rd, 32'h87);
        wr(12'h008, 32'h8000_0087, 1);
        wr(12'h00C, 32'h3B);
        // R4 clear with locality
        wr(12'h010, 32'h4);
        rd("R4 cleared", 12'h010);     chk("R4 cleared lit", last_rd, 32'h0);
        // R2 release raises flag; R4 clear without locality ignored
        wr(12'h000, 32'h20);
        rd("R2 access free", 12'h000);
        wr(12'h010, 32'hFF, 1);
        rd("R4 held pending", 12'h010); chk("R4 held lit", last_rd, 32'h4);
        rd("R3 status unheld", 12'h018);
        wr(12'h000, 32'h02);
        wr(12'h010, 32'h87);
        // R7 ready phase
        wr(12'h018, 32'h40);
        rd("R7 status ready", 12'h018); chk("R7 status lit", last_rd, 32'h0000_10C8);
        rd("R7 cmd rdy flag", 12'h010);
        wr(12'h010, 32'h80);
        // R8 command of length 10
        begin
            logic [7:0] cmd [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A,
                                     8'h00, 8'h00, 8'h01, 8'h44};
            for (int i = 0; i < 10; i++) begin
                wr(12'h024, {24'h0, cmd[i]});
                if (i == 3) rd("R8 partial status", 12'h018);
                if (i == 6) begin
                    wr(12'h018, 32'h20); // R9 early go ignored
                    rd("R9 early go ignored", 12'h018);
                end
            end
        end
        rd("R8 complete status", 12'h018); chk("R8 complete lit", last_rd, 32'h0000_0680);
        rd("R8 valid flag", 12'h010);
        wr(12'h010, 32'h2);
        // R9 start
        wr(12'h018, 32'h20);
        rd("R9 exec status", 12'h018);  chk("R9 exec lit", last_rd, 32'h80);
        @(negedge clk); eng_rd_idx = 4'd8; #1;
        chk("R9 engine view", {24'h0, eng_rd_data}, 32'h01);
        // R10 cancel keeps executing
        wr(12'h018, 32'h40);
        rd("R10 still exec", 12'h018);
        // R11 response
        eng_write(0, 8'hDE); eng_write(1, 8'hAD); eng_write(2, 8'hBE); eng_write(3, 8'hEF);
        eng_finish(4);
        rd("R11 avail status", 12'h018); chk("R11 avail lit", last_rd, 32'h0000_0490);
        rd("R11 avail flag", 12'h010);
        for (int i = 0; i < 4; i++) rd("R11 response byte", 12'h024);
        rd("R11 drained", 12'h024);     chk("R11 drained lit", last_rd, 32'hFF);
        rd("R12 drained status", 12'h018);
        wr(12'h010, 32'h87, 1);
        // R8/R12 oversize length: buffer fills, expected stays 1
        wr(12'h018, 32'h40);
        begin
            logic [7:0] hdr [6] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h14};
            for (int i = 0; i < 17; i++) wr(12'h024, (i < 6) ? {24'h0, hdr[i]} : 32'(i));
        end
        rd("R12 full status", 12'h018); chk("R12 full lit", last_rd, 32'h88);
        wr(12'h018, 32'h20);
        rd("R9 go refused", 12'h018);
        // short length field: complete at six bytes; zero-length response
        wr(12'h018, 32'h40);
        for (int i = 0; i < 6; i++) wr(12'h024, (i == 5) ? 32'h03 : 32'h00);
        rd("R8 short complete", 12'h018);
        wr(12'h018, 32'h20);
        eng_finish(0);
        rd("R11 empty response", 12'h018); chk("R11 empty lit", last_rd, 32'h80);
        rd("R11 no avail flag", 12'h010);
        // R3 data read unheld
        wr(12'h000, 32'h20);
        rd("R3 data unheld", 12'h024);
        rd("R5 final int sts", 12'h010);
        run = 0;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule